// File: doc/BRIEF.md
# Tagged Response Router

This block sits at the return side of a shared memory path. Several requesters share that path: a number of processor caches plus the result printer of a command interface. Each response carries a small channel tag of width clog2(1+N_CPU). The router removes the tag and uses it as the index of the output channel that gets the response. Channel 0 is the result printer. Channels 1 to N_CPU are the processor caches.

Processor channels receive a shortened address. The high prefix bits that were added on the request side are dropped, and only the low CPU_AW bits remain. The printer channel receives the whole address. Each channel has its own valid/ready pair and can stall for any number of cycles.

The router holds no buffer. It passes back the ready of the selected channel, so the upstream source keeps the response steady until that channel takes it. If a tag names no existing channel, the response is consumed at once and reaches no output. It also sets an error flag that stays set until reset.

Top module: `resp_router`

## Requirements
- R1: With in_valid high and in_tag = k (0 ≤ k ≤ N_CPU), out_valid bit k is high and every other out_valid bit is low. Bit 0 is the printer and bit k is processor k.
- R2: At no time is more than one out_valid bit high.
- R3: prn_addr always equals the full in_addr.
- R4: The processor address slice cpu_addr[(k-1)*CPU_AW +: CPU_AW] equals in_addr[CPU_AW-1:0]. out_data equals in_data.
- R5: For a legal tag, in_ready equals out_ready of the selected channel. The ready inputs of all other channels have no effect on in_ready.
- R6: While the selected channel holds out_ready low, in_ready stays low and that channel's out_valid stays high on every cycle.
- R7: A valid response with in_tag > N_CPU gives in_ready high and all out_valid bits low. err_flag is high from the next clock edge on.
- R8: err_flag is low after reset and, once set, stays high until rst_n is asserted again.
- R9: With in_valid low, every out_valid bit is low and err_flag is not set, whatever in_tag holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_valid | input | 1 | Response present |
| in_ready | output | 1 | Response accepted this cycle |
| in_tag | input | TAG_W | Destination channel index |
| in_addr | input | FULL_AW | Full response address |
| in_data | input | DW | Response data |
| out_valid | output | N_CPU+1 | Per-channel valid, bit 0 = printer |
| out_ready | input | N_CPU+1 | Per-channel ready, bit 0 = printer |
| prn_addr | output | FULL_AW | Address for the printer channel |
| cpu_addr | output | N_CPU*CPU_AW | Stripped addresses, processor k at slice k-1 |
| out_data | output | DW | Data shared by all channels |
| err_flag | output | 1 | Sticky flag for an unmapped tag |

## Verification
Two functions can fall in the same cycle: the stall hand-back of ready, and the routing decision made while other channels are ready. The bench provokes this by stalling the selected channel while every other channel raises ready. It then judges that in_ready stays low and that only the selected valid is high. The illegal-tag drop and the error flag are also checked together: in_ready must be high in the drop cycle, and the flag must rise only after the following edge.

// File: rtl/resp_router_pkg.sv
package resp_router_pkg;
  typedef enum logic {CH_PRINTER = 1'b0, CH_CPU = 1'b1} ch_kind_e;

  function automatic int tag_width(input int n_cpu);
    return (n_cpu < 1) ? 1 : $clog2(n_cpu + 1);
  endfunction

  function automatic ch_kind_e kind_of(input int idx);
    return (idx == 0) ? CH_PRINTER : CH_CPU;
  endfunction
endpackage

// File: rtl/resp_router_rst_sync.sv
module resp_router_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_sync = sync_q[1];
endmodule

// File: rtl/resp_router_sel.sv
module resp_router_sel #(
  parameter int NCH   = 5,
  parameter int TAG_W = 3
) (
  input  logic [TAG_W-1:0] tag,
  output logic [NCH-1:0]   sel,
  output logic             legal
);
  localparam int TAG_SPAN = 1 << TAG_W;

  generate
    for (genvar g = 0; g < NCH; g++) begin : g_dec
      assign sel[g] = (tag == TAG_W'(g));
    end
    if (TAG_SPAN > NCH) begin : g_partial
      assign legal = (tag < TAG_W'(NCH));
    end else begin : g_full
      assign legal = 1'b1;
    end
  endgenerate
endmodule

// File: rtl/resp_router_addr.sv
module resp_router_addr
  import resp_router_pkg::*;
#(
  parameter int N_CPU   = 4,
  parameter int FULL_AW = 16,
  parameter int CPU_AW  = 12
) (
  input  logic [FULL_AW-1:0]      addr,
  output logic [FULL_AW-1:0]      prn_addr,
  output logic [N_CPU*CPU_AW-1:0] cpu_addr
);
  assign prn_addr = addr;

  generate
    for (genvar g = 1; g <= N_CPU; g++) begin : g_cpu
      if (kind_of(g) == CH_CPU) begin : g_strip
        assign cpu_addr[(g-1)*CPU_AW +: CPU_AW] = addr[CPU_AW-1:0];
      end
    end
  endgenerate
endmodule

// File: rtl/resp_router_err.sv
module resp_router_err (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  output logic err_o
);
  logic err_q, err_d, err_en;

  always_comb begin
    err_en = set_i & ~err_q;
    err_d  = err_q;
    if (err_en) err_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      err_q <= 1'b0;
    else if (err_en) err_q <= err_d;
  end

  assign err_o = err_q;

  AST_ERR_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    set_i |=> err_o); // R7
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |=> err_o); // R8
endmodule

// File: rtl/resp_router.sv
module resp_router
  import resp_router_pkg::*;
#(
  parameter int N_CPU   = 4,
  parameter int FULL_AW = 16,
  parameter int CPU_AW  = 12,
  parameter int DW      = 12,
  parameter int NCH     = N_CPU + 1,
  parameter int TAG_W   = tag_width(N_CPU)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    in_valid,
  output logic                    in_ready,
  input  logic [TAG_W-1:0]        in_tag,
  input  logic [FULL_AW-1:0]      in_addr,
  input  logic [DW-1:0]           in_data,
  output logic [NCH-1:0]          out_valid,
  input  logic [NCH-1:0]          out_ready,
  output logic [FULL_AW-1:0]      prn_addr,
  output logic [N_CPU*CPU_AW-1:0] cpu_addr,
  output logic [DW-1:0]           out_data,
  output logic                    err_flag
);
  logic           rst_n_sync;
  logic [NCH-1:0] sel;
  logic           legal;
  logic           drop;

  resp_router_rst_sync u_rst (
    .clk(clk), .rst_n(rst_n), .rst_n_sync(rst_n_sync)
  );

  resp_router_sel #(.NCH(NCH), .TAG_W(TAG_W)) u_sel (
    .tag(in_tag), .sel(sel), .legal(legal)
  );

  resp_router_addr #(.N_CPU(N_CPU), .FULL_AW(FULL_AW), .CPU_AW(CPU_AW)) u_addr (
    .addr(in_addr), .prn_addr(prn_addr), .cpu_addr(cpu_addr)
  );

  always_comb begin
    out_valid = in_valid ? (sel & {NCH{legal}}) : '0;
    in_ready  = legal ? |(sel & out_ready) : 1'b1;
    drop      = in_valid & ~legal;
  end

  assign out_data = in_data;

  resp_router_err u_err (
    .clk(clk), .rst_n(rst_n_sync), .set_i(drop), .err_o(err_flag)
  );

  AST_ONE_DEST: assert property (@(posedge clk) disable iff (!rst_n_sync)
    $onehot0(out_valid)); // R2
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n_sync)
    !in_valid |-> (out_valid == '0)); // R9
  AST_BAD_DROP: assert property (@(posedge clk) disable iff (!rst_n_sync)
    (in_valid && (int'(in_tag) > N_CPU)) |-> (in_ready && out_valid == '0)); // R7
  AST_READY_PASS: assert property (@(posedge clk) disable iff (!rst_n_sync)
    (in_valid && (int'(in_tag) <= N_CPU)) |-> (in_ready == |(out_ready & out_valid))); // R5
  AST_HIT_DEST: assert property (@(posedge clk) disable iff (!rst_n_sync)
    (in_valid && (int'(in_tag) <= N_CPU)) |-> ($countones(out_valid) == 1)); // R1
endmodule

// File: tb/resp_router_bench.sv
module resp_router_bench;
  localparam int PERIOD  = 10;
  localparam int N_CPU   = 4;
  localparam int NCH     = 5;
  localparam int TAG_W   = 3;
  localparam int FULL_AW = 16;
  localparam int CPU_AW  = 12;
  localparam int DW      = 12;

  logic                    clk = 1'b0;
  logic                    rst_n;
  logic                    in_valid;
  logic                    in_ready;
  logic [TAG_W-1:0]        in_tag;
  logic [FULL_AW-1:0]      in_addr;
  logic [DW-1:0]           in_data;
  logic [NCH-1:0]          out_valid;
  logic [NCH-1:0]          out_ready;
  logic [FULL_AW-1:0]      prn_addr;
  logic [N_CPU*CPU_AW-1:0] cpu_addr;
  logic [DW-1:0]           out_data;
  logic                    err_flag;

  int n_run = 0;
  int n_bad = 0;

  always #(PERIOD/2) clk = ~clk;

  resp_router u_resp_router (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_tag(in_tag), .in_addr(in_addr), .in_data(in_data),
    .out_valid(out_valid), .out_ready(out_ready), .prn_addr(prn_addr),
    .cpu_addr(cpu_addr), .out_data(out_data), .err_flag(err_flag)
  );

  // {tag, addr, ready mask, expected valid mask, expected in_ready}
  localparam logic [29:0] VEC [8] = '{
    {3'd0, 16'hA123, 5'b11111, 5'b00001, 1'b1},
    {3'd1, 16'hB456, 5'b11111, 5'b00010, 1'b1},
    {3'd2, 16'h0FFF, 5'b00100, 5'b00100, 1'b1},
    {3'd3, 16'hFFFF, 5'b00000, 5'b01000, 1'b0},
    {3'd4, 16'h1234, 5'b01111, 5'b10000, 1'b0},
    {3'd4, 16'h8001, 5'b10000, 5'b10000, 1'b1},
    {3'd0, 16'h7777, 5'b11110, 5'b00001, 1'b0},
    {3'd2, 16'hC0DE, 5'b11011, 5'b00100, 1'b0}
  };

  task automatic chk(input logic ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    n_run++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_bad);
    $finish;
  endtask

  initial begin
    #(PERIOD*200000);
    n_run++; n_bad++;
    $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
    summary();
  end

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; in_tag = '0; in_addr = '0; in_data = '0;
    out_ready = '0;
    #(PERIOD*2 + 1);
    chk(out_valid == '0, "R9 reset valid", 32'(out_valid), 0);
    chk(err_flag == 1'b0, "R8 reset flag", 32'(err_flag), 0);
    @(negedge clk); rst_n = 1'b1;
    repeat (3) @(negedge clk);

    for (int i = 0; i < 8; i++) begin
      logic [2:0]  t;
      logic [15:0] a;
      t = VEC[i][29:27]; a = VEC[i][26:11];
      in_valid = 1'b1; in_tag = t; in_addr = a; in_data = a[11:0] ^ 12'h5A5;
      out_ready = VEC[i][10:6];
      #1;
      chk(out_valid == VEC[i][5:1], "R1 route", 32'(out_valid), 32'(VEC[i][5:1]));
      chk(in_ready == VEC[i][0], "R5 ready", 32'(in_ready), 32'(VEC[i][0]));
      if (t == 3'd0)
        chk(prn_addr == a, "R3 printer addr", 32'(prn_addr), 32'(a));
      else
        chk(cpu_addr[(t-1)*CPU_AW +: CPU_AW] == a[11:0], "R4 cpu addr",
            32'(cpu_addr[(t-1)*CPU_AW +: CPU_AW]), 32'(a[11:0]));
      chk(out_data == (a[11:0] ^ 12'h5A5), "R4 data", 32'(out_data),
          32'(a[11:0] ^ 12'h5A5));
      @(negedge clk);
    end

    // R6: stall on processor 3 while every other channel is ready
    in_valid = 1'b1; in_tag = 3'd3; in_addr = 16'h4321; out_ready = 5'b10111;
    for (int c = 0; c < 3; c++) begin
      #1;
      chk(out_valid == 5'b01000 && !in_ready, "R6 stall hold",
          {in_ready, 27'd0, out_valid}, 32'h0000_0008);
      @(negedge clk);
    end
    out_ready = 5'b01000; #1;
    chk(in_ready == 1'b1, "R6 release", 32'(in_ready), 1);
    @(negedge clk);

    // R9: illegal tag with in_valid low does nothing
    in_valid = 1'b0; in_tag = 3'd6; out_ready = '1; #1;
    chk(out_valid == '0, "R9 idle valid", 32'(out_valid), 0);
    @(negedge clk);
    chk(err_flag == 1'b0, "R9 idle flag", 32'(err_flag), 0);

    // R7: illegal tag is dropped, flag rises after the edge
    in_valid = 1'b1; in_tag = 3'd5; out_ready = '0; #1;
    chk(in_ready == 1'b1, "R7 drop ready", 32'(in_ready), 1);
    chk(out_valid == '0, "R7 drop valid", 32'(out_valid), 0);
    chk(err_flag == 1'b0, "R7 flag before edge", 32'(err_flag), 0);
    @(negedge clk);
    chk(err_flag == 1'b1, "R7 flag set", 32'(err_flag), 1);

    // R8: flag holds, reset clears it
    in_valid = 1'b0; in_tag = 3'd0;
    repeat (4) @(negedge clk);
    chk(err_flag == 1'b1, "R8 sticky", 32'(err_flag), 1);
    rst_n = 1'b0; #1;
    chk(err_flag == 1'b0, "R8 reset clears", 32'(err_flag), 0);
    @(negedge clk); rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(err_flag == 1'b0, "R8 after reset", 32'(err_flag), 0);

    summary();
  end
endmodule